// File: doc/BRIEF.md
# Flash Read Accelerator with Selectable Acceleration Mode

This block sits between a processor's request port (instruction and data reads) and a slow flash read port that returns a 128-bit line. It keeps three line buffers: one for the last instruction line, one for the last data line, and one for the next sequential instruction line, which is fetched ahead of need. For every request it looks up the buffers and consults a decision table. The table is selected by a mode setting and by whether the request is sequential. From that decision the block either answers from a buffer or starts a flash read, and it pulses a ready strobe when the word is available.

Software writes two settings through a small write port. One is the acceleration mode: 0 is off, 1 is partial and 2 is full. The other is the flash access time, in clocks. When acceleration is off, a value already held in a buffer is still used, which avoids a flash read and saves power. The response is then delayed to the full access time so that execution timing is the same as with no buffers.

Top module: `flash_accel`

## Requirements
- R1: After reset, the mode is 0 and the access time is 7 clocks. All buffers are empty, `rsp_ready` is low and `fl_rd` is low.
- R2: In mode 0, every request answers exactly the access time after acceptance. A request whose line is buffered raises no `fl_rd`.
- R3: In mode 1, a sequential instruction request that hits a buffer answers one clock after acceptance with no flash read. A non-sequential instruction request starts a flash read even when it hits.
- R4: In mode 1, every data request (`req_data`=1) starts a flash read whether or not it hits the data buffer.
- R5: In mode 2, any request that hits its own buffers answers one clock after acceptance with no flash read. Instruction requests look in the instruction and next-line buffers; data requests look in the data buffer.
- R6: In every mode, a request whose line is not buffered starts a flash read that lasts the access time and fills the buffer of its kind.
- R7: After an instruction response in mode 1 or 2, the next line (line+1) is fetched into the next-line buffer unless that buffer already holds it. In mode 0 no such fetch occurs.
- R8: The access-time setting (`cfg_sel`=1, `cfg_wdata`[2:0]) spans 1 to 7 clocks, and 0 acts as 7. With 1, every response, whether a hit or a miss, arrives one clock after acceptance.
- R9: A request is sequential only when it is an instruction request and its address equals the previous instruction address plus 4 within the same 16-byte line (address bits [15:4]). A step across a line boundary is non-sequential.
- R10: While the next-line fetch is running, a request that needs a flash read is accepted at once. The next-line fetch is abandoned and the next-line buffer is emptied. A request that needs no flash read waits for the next-line fetch to end.
- R11: A mode write (`cfg_sel`=0, `cfg_wdata`[1:0]) empties all three buffers and abandons a running next-line fetch. Value 3 behaves as mode 0.
- R12: `rsp_ready` is a one-clock pulse, and `rsp_data` is valid in that clock. `fl_rd` stays high with a stable `fl_addr` for the whole read, and `fl_rdata` is taken in its last clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | 0: mode, 1: access time |
| cfg_wdata | input | 3 | Setting value |
| req_valid | input | 1 | Request held until `rsp_ready` |
| req_data | input | 1 | 1: data request, 0: instruction request |
| req_addr | input | 16 | Byte address, word aligned |
| rsp_ready | output | 1 | One-clock response strobe |
| rsp_data | output | 32 | Response word |
| fl_rd | output | 1 | Flash read in progress |
| fl_addr | output | 12 | Flash line address |
| fl_rdata | input | 128 | Flash line, valid while `fl_rd` |

## Verification
The assertions rely on a few properties of the inputs. A requester keeps `req_valid` high and its address steady until `rsp_ready`, then drops it in that same clock. Addresses are word aligned. Mode writes arrive only when no demand read is in flight, although they may arrive during a next-line fetch. The bench's request task follows these rules, writes settings only between requests, and issues back-to-back requests only to exercise the abort of a next-line fetch.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_PREF} fa_state_e;
    localparam int BUF_INS  = 0;
    localparam int BUF_DAT  = 1;
    localparam int BUF_NEXT = 2;
    localparam int NUM_BUF  = 3;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int TAGW = 12
) (
    input  logic            valid,
    input  logic [TAGW-1:0] tag,
    input  logic [TAGW-1:0] line,
    output logic            hit
);
    assign hit = valid && (tag == line);
endmodule

// File: rtl/fa_time_decode.sv
module fa_time_decode #(
    parameter int TW = 3
) (
    input  logic [TW-1:0] raw,
    output logic [TW-1:0] eff
);
    // zero selects the longest access time
    assign eff = (raw == '0) ? '1 : raw;
endmodule

// File: rtl/fa_policy.sv
module fa_policy (
    input  logic [1:0] mode,
    input  logic       is_data,
    input  logic       seq,
    input  logic       hit,
    output logic       fast,
    output logic       from_buf
);
    // fast: answered in one clock; from_buf: no flash read needed
    assign fast     = hit && ((mode == 2'd2) || ((mode == 2'd1) && !is_data && seq));
    assign from_buf = hit && ((mode == 2'd0) || fast);
endmodule

// File: rtl/flash_accel.sv
module flash_accel
    import flash_accel_pkg::*;
#(
    parameter int AW    = 16,
    parameter int WW    = 32,
    parameter int WORDS = 4,
    parameter int TW    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic                          cfg_sel,
    input  logic [TW-1:0]                 cfg_wdata,
    input  logic                          req_valid,
    input  logic                          req_data,
    input  logic [AW-1:0]                 req_addr,
    output logic                          rsp_ready,
    output logic [WW-1:0]                 rsp_data,
    output logic                          fl_rd,
    output logic [AW-$clog2(WORDS*WW/8)-1:0] fl_addr,
    input  logic [WW*WORDS-1:0]           fl_rdata
);
    localparam int BB   = $clog2(WW/8);
    localparam int WB   = $clog2(WORDS);
    localparam int OB   = BB + WB;
    localparam int TAGW = AW - OB;
    localparam int LW   = WW * WORDS;

    typedef struct packed {
        logic            v;
        logic [TAGW-1:0] tag;
        logic [LW-1:0]   data;
    } buf_t;

    typedef struct packed {
        fa_state_e         st;
        logic [TW-1:0]     cnt;
        logic [TAGW-1:0]   line;
        logic [WB-1:0]     word;
        logic              fetch;
        logic              is_data;
        logic [WW-1:0]     hold;
        buf_t [NUM_BUF-1:0] bufs;
        logic              prev_v;
        logic [AW-1:0]     prev_addr;
        logic [1:0]        mode;
        logic [TW-1:0]     tim;
    } regs_t;

    localparam regs_t RST = '{st: ST_IDLE, cnt: '0, line: '0, word: '0, fetch: 1'b0,
                              is_data: 1'b0, hold: '0, bufs: '0, prev_v: 1'b0,
                              prev_addr: '0, mode: 2'd0, tim: '1};

    regs_t q, d;

    logic [TAGW-1:0]    req_line, next_line;
    logic [WB-1:0]      req_word;
    logic [NUM_BUF-1:0] hit;
    logic               hit_sel, seq, fast, from_buf, need_fetch, take;
    logic               mode_wr, tim_wr, pf_have;
    logic [1:0]         mode_eff, src_idx;
    logic [TW-1:0]      tim_eff;
    buf_t               src_buf;
    logic [WW-1:0]      hold_w;

    assign req_line  = req_addr[AW-1:OB];
    assign req_word  = req_addr[OB-1:BB];
    assign next_line = q.line + 1'b1;
    assign mode_wr   = cfg_we && !cfg_sel;
    assign tim_wr    = cfg_we && cfg_sel;
    assign mode_eff  = (q.mode == 2'd3) ? 2'd0 : q.mode;

    for (genvar k = 0; k < NUM_BUF; k++) begin : g_match
        fa_tag_match #(.TAGW(TAGW)) u_match (
            .valid(q.bufs[k].v),
            .tag  (q.bufs[k].tag),
            .line (req_line),
            .hit  (hit[k])
        );
    end

    fa_time_decode #(.TW(TW)) u_time (
        .raw(q.tim),
        .eff(tim_eff)
    );

    assign hit_sel = req_data ? hit[BUF_DAT] : (hit[BUF_INS] | hit[BUF_NEXT]);
    assign src_idx = req_data ? 2'(BUF_DAT) : (hit[BUF_INS] ? 2'(BUF_INS) : 2'(BUF_NEXT));
    assign seq     = !req_data && q.prev_v
                   && (req_addr == q.prev_addr + AW'(WW/8))
                   && (req_line == q.prev_addr[AW-1:OB]);

    fa_policy u_policy (
        .mode    (mode_eff),
        .is_data (req_data),
        .seq     (seq),
        .hit     (hit_sel),
        .fast    (fast),
        .from_buf(from_buf)
    );

    assign need_fetch = !from_buf;
    assign take    = req_valid && !mode_wr
                   && ((q.st == ST_IDLE) || ((q.st == ST_PREF) && need_fetch));
    assign src_buf = q.bufs[src_idx];
    assign hold_w  = src_buf.data[req_word*WW +: WW];
    assign pf_have = q.bufs[BUF_NEXT].v && (q.bufs[BUF_NEXT].tag == next_line);

    always_comb begin
        d = q;
        case (q.st)
            ST_WAIT: begin
                if (q.cnt == TW'(1)) begin
                    if (q.fetch)
                        d.bufs[q.is_data ? BUF_DAT : BUF_INS] = '{v: 1'b1, tag: q.line, data: fl_rdata};
                    if (!q.is_data && (mode_eff != 2'd0) && !pf_have) begin
                        d.st    = ST_PREF;
                        d.cnt   = tim_eff;
                        d.line  = next_line;
                        d.fetch = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PREF: begin
                if (q.cnt == TW'(1)) begin
                    d.bufs[BUF_NEXT] = '{v: 1'b1, tag: q.line, data: fl_rdata};
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
        if (take) begin
            if (q.st == ST_PREF)
                d.bufs[BUF_NEXT].v = 1'b0;
            d.st      = ST_WAIT;
            d.cnt     = fast ? TW'(1) : tim_eff;
            d.line    = req_line;
            d.word    = req_word;
            d.fetch   = need_fetch;
            d.is_data = req_data;
            d.hold    = hold_w;
            if (!req_data) begin
                d.prev_v    = 1'b1;
                d.prev_addr = req_addr;
                if (!need_fetch && !hit[BUF_INS]) begin
                    d.bufs[BUF_INS]    = q.bufs[BUF_NEXT];
                    d.bufs[BUF_NEXT].v = 1'b0;
                end
            end
        end
        if (tim_wr)
            d.tim = cfg_wdata;
        if (mode_wr) begin
            d.mode = cfg_wdata[1:0];
            for (int k = 0; k < NUM_BUF; k++)
                d.bufs[k].v = 1'b0;
            if (d.st == ST_PREF)
                d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign rsp_ready = (q.st == ST_WAIT) && (q.cnt == TW'(1));
    assign rsp_data  = q.fetch ? fl_rdata[q.word*WW +: WW] : q.hold;
    assign fl_rd     = ((q.st == ST_WAIT) && q.fetch) || (q.st == ST_PREF);
    assign fl_addr   = q.line;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R12
    AST_FLASH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd && !rsp_ready && (q.st == ST_WAIT)) |=> (fl_rd && $stable(fl_addr))); // R12
    AST_MODE1_DATA_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_data && (mode_eff == 2'd1)) |=> fl_rd); // R4
    AST_MODE0_FULL_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (mode_eff == 2'd0)) |=> (q.cnt == $past(tim_eff))); // R2
    AST_NO_PREFETCH_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PREF) |-> (mode_eff != 2'd0)); // R7
    AST_MODE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !(q.bufs[0].v || q.bufs[1].v || q.bufs[2].v)); // R11
    AST_FAST_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fast) |=> (rsp_ready && !fl_rd)); // R5
endmodule

// File: tb/tb_flash_accel.sv
module tb_flash_accel;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [2:0]   cfg_wdata = '0;
    logic         req_valid = 1'b0, req_data = 1'b0;
    logic [15:0]  req_addr = '0;
    logic         rsp_ready, fl_rd;
    logic [31:0]  rsp_data;
    logic [11:0]  fl_addr;
    logic [127:0] fl_rdata;

    int n_cmp = 0, n_bad = 0;
    bit model_on = 0;

    always #4 clk = ~clk;

    flash_accel dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_data(req_data), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] fw(input int line, input int w);
        return 32'hC3A50000 ^ (32'(line) << 4) ^ 32'(w);
    endfunction

    always_comb
        for (int w = 0; w < 4; w++) fl_rdata[w*32 +: 32] = fw(int'(fl_addr), w);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference state
    int m_st = 0, m_cnt = 0, m_line = 0, m_word = 0, m_isd = 0, m_mode = 0, m_tim = 7, m_pa = 0;
    bit m_fetch = 0, m_pv = 0;
    bit lv[3] = '{0, 0, 0};
    int ltag[3] = '{0, 0, 0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_line = 0; m_word = 0; m_isd = 0; m_mode = 0; m_tim = 7;
            m_pa = 0; m_fetch = 0; m_pv = 0;
            for (int k = 0; k < 3; k++) begin lv[k] = 0; ltag[k] = 0; end
        end else begin
            int me, te, rl, rw, nl, o_st;
            bit mwr, twr, hi, hd, hp, hit, sq, fast, fl, take, pfh;
            me  = (m_mode == 3) ? 0 : m_mode;
            te  = (m_tim == 0) ? 7 : m_tim;
            mwr = cfg_we && !cfg_sel;
            twr = cfg_we && cfg_sel;
            rl  = int'(req_addr) >> 4;
            rw  = (int'(req_addr) >> 2) & 3;
            hi  = lv[0] && ltag[0] == rl;
            hd  = lv[1] && ltag[1] == rl;
            hp  = lv[2] && ltag[2] == rl;
            hit = req_data ? hd : (hi || hp);
            sq  = !req_data && m_pv && (int'(req_addr) == m_pa + 4) && (rl == (m_pa >> 4));
            fast = hit && (me == 2 || (me == 1 && !req_data && sq));
            fl  = !(hit && (me == 0 || fast));
            take = req_valid && !mwr && (m_st == 0 || (m_st == 2 && fl));
            nl  = (m_line + 1) & 12'hFFF;
            pfh = lv[2] && ltag[2] == nl;
            o_st = m_st;
            if (m_st == 1) begin
                if (m_cnt == 1) begin
                    if (m_fetch) begin lv[m_isd] = 1; ltag[m_isd] = m_line; end
                    if (m_isd == 0 && me != 0 && !pfh) begin
                        m_st = 2; m_cnt = te; m_line = nl; m_fetch = 1;
                    end else m_st = 0;
                end else m_cnt--;
            end else if (m_st == 2) begin
                if (m_cnt == 1) begin lv[2] = 1; ltag[2] = m_line; m_st = 0; end
                else m_cnt--;
            end
            if (take) begin
                if (o_st == 2) lv[2] = 0;
                if (!req_data && !fl && !hi) begin
                    lv[0] = lv[2]; ltag[0] = ltag[2]; lv[2] = 0;
                end
                m_st = 1; m_cnt = fast ? 1 : te; m_line = rl; m_word = rw;
                m_fetch = fl; m_isd = req_data ? 1 : 0;
                if (!req_data) begin m_pv = 1; m_pa = int'(req_addr); end
            end
            if (twr) m_tim = int'(cfg_wdata);
            if (mwr) begin
                m_mode = int'(cfg_wdata[1:0]);
                for (int k = 0; k < 3; k++) lv[k] = 0;
                if (m_st == 2) m_st = 0;
            end
        end
    end

    // per-clock comparison against the reference (R12 handshake and data)
    always @(negedge clk) if (model_on) begin
        bit e_rdy, e_fl;
        e_rdy = (m_st == 1) && (m_cnt == 1);
        e_fl  = (m_st == 1 && m_fetch) || (m_st == 2);
        chk(rsp_ready == e_rdy, "R12 rsp_ready", rsp_ready, e_rdy);
        chk(fl_rd == e_fl, "R12 fl_rd", fl_rd, e_fl);
        if (e_fl) chk(int'(fl_addr) == m_line, "R12 fl_addr", fl_addr, m_line);
        if (e_rdy) chk(rsp_data == fw(m_line, m_word), "R12 rsp_data", rsp_data, fw(m_line, m_word));
    end

    task automatic cfg(input bit sel, input int v);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = 3'(v);
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic do_req(input int a, input bit dat, input int exp_lat, input bit exp_fl, input string tag);
        int n = 0;
        bit saw = 0;
        @(negedge clk); req_valid = 1; req_addr = 16'(a); req_data = dat;
        do begin
            @(negedge clk); n++;
            if (fl_rd) saw = 1;
        end while (!rsp_ready && n < 60);
        req_valid = 0;
        chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
        chk(saw == exp_fl, {tag, " flash read"}, saw, exp_fl);
    endtask

    task automatic idle_nofl(input int cyc, input string tag);
        int c = 0;
        repeat (cyc) begin @(negedge clk); if (fl_rd) c++; end
        chk(c == 0, tag, c, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_ready == 0, "R1 ready in reset", rsp_ready, 0);
        chk(fl_rd == 0, "R1 flash idle in reset", fl_rd, 0);
        rst_n = 1; model_on = 1;
        idle_nofl(3, "R1 no read after reset");
        // mode 0, default time 7
        do_req('h0100, 0, 7, 1, "R1 R6 miss default time");
        repeat (4) @(negedge clk);
        do_req('h0100, 0, 7, 0, "R2 hit full time");
        do_req('h0104, 0, 7, 0, "R2 sequential hit full time");
        idle_nofl(10, "R7 no prefetch in mode 0");
        // mode 1, time 3
        cfg(1, 3); cfg(0, 1);
        do_req('h0200, 0, 3, 1, "R6 mode1 miss");
        repeat (6) @(negedge clk);
        do_req('h0204, 0, 1, 0, "R3 sequential hit");
        repeat (6) @(negedge clk);
        do_req('h0200, 0, 3, 1, "R3 branch hit still reads");
        repeat (6) @(negedge clk);
        do_req('h0300, 1, 3, 1, "R4 data miss");
        repeat (3) @(negedge clk);
        do_req('h0300, 1, 3, 1, "R4 data hit still reads");
        repeat (3) @(negedge clk);
        do_req('h020C, 0, 3, 1, "R9 skip within line");
        repeat (6) @(negedge clk);
        do_req('h0210, 0, 3, 1, "R9 line crossing not sequential");
        repeat (6) @(negedge clk);
        do_req('h0214, 0, 1, 0, "R9 sequential within line");
        repeat (6) @(negedge clk);
        // mode 2
        cfg(0, 2);
        do_req('h0400, 0, 3, 1, "R11 buffers emptied by mode write");
        repeat (6) @(negedge clk);
        do_req('h0410, 0, 1, 0, "R7 R5 next line prefetched");
        repeat (6) @(negedge clk);
        do_req('h0500, 1, 3, 1, "R6 data miss");
        repeat (3) @(negedge clk);
        do_req('h0508, 1, 1, 0, "R5 data hit");
        repeat (3) @(negedge clk);
        do_req('h0418, 0, 1, 0, "R5 non-sequential hit");
        repeat (6) @(negedge clk);
        // demand miss aborts prefetch
        do_req('h0600, 0, 3, 1, "R6 miss before abort");
        do_req('h0800, 0, 3, 1, "R10 demand over prefetch");
        do_req('h0900, 1, 3, 1, "R10 data demand over prefetch");
        repeat (6) @(negedge clk);
        do_req('h0420, 0, 3, 1, "R10 prefetch buffer emptied");
        repeat (6) @(negedge clk);
        // access time settings
        cfg(1, 0);
        do_req('h0A00, 0, 7, 1, "R8 zero means seven");
        repeat (12) @(negedge clk);
        cfg(1, 1);
        do_req('h0C00, 0, 1, 1, "R8 one clock miss");
        repeat (4) @(negedge clk);
        do_req('h0C08, 0, 1, 0, "R8 one clock hit");
        repeat (4) @(negedge clk);
        // mode 3 acts as mode 0
        cfg(1, 4); cfg(0, 3);
        do_req('h0C00, 0, 4, 1, "R11 emptied, mode 3");
        idle_nofl(8, "R11 R7 mode 3 no prefetch");
        do_req('h0C00, 0, 4, 0, "R11 mode 3 hit full time");
        // mode write abandons a running prefetch
        cfg(0, 2);
        do_req('h0E00, 0, 4, 1, "R6 miss before mode write");
        cfg(0, 2);
        idle_nofl(6, "R11 prefetch abandoned");
        do_req('h0E10, 0, 4, 1, "R11 next line not kept");
        repeat (10) @(negedge clk);
        model_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule